// File: doc/BRIEF.md
# I2C Bus Monitor Receiver

This block observes an I2C bus without taking part in it. It samples SCL and SDA in the system clock domain and recognises START, repeated START and STOP conditions. It shifts in each 8-bit word and follows the ninth (acknowledge) clock. When an address word selects the block, it raises an event and then reports every following byte of that transfer, in either direction, until the next START or STOP. Each reported byte stays in a holding register until the next byte completes. An interrupt-pending flag stays set until it is cleared by a one-cycle strobe.

Three configuration inputs set the mode. In monitor mode the block never pulls SDA low, not even for ACK. Bytes that another slave drives in a read transfer are still captured and reported. In monitor mode the block pulls SCL low only when clock control is enabled, and match-all then accepts every address. Outside monitor mode the block behaves as a plain slave receiver. It acknowledges a matching address and each written byte, and it may always stretch the clock. Match-all and clock control have no effect in that mode.

The framing state machine has six states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts the address word.
- `ST_ADDR_ACK`: the acknowledge slot after a matched address.
- `ST_DATA`: shifts a data word.
- `ST_DATA_ACK`: the acknowledge slot after a data word.
- `ST_SKIP`: an unmatched transfer.

Its transitions are:
- START from any state goes to `ST_ADDR`. STOP goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the eighth rising SCL if the address matches, and to `ST_SKIP` if it does not.
- `ST_DATA` goes to `ST_DATA_ACK` on the eighth rising SCL.
- Either ACK state goes to `ST_DATA` on the second falling SCL after entry.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, `irq_pending` and `evt_valid` are 0 and both `scl_o` and `sda_o` are 1 (released).
- R2: START (SDA falls while SCL is high) begins an address word from any state, including a repeated START. STOP (SDA rises while SCL is high) ends the transfer. After a repeated START to an unmatched address, no further bytes are reported.
- R3: The address word is the 7-bit address (bits 7..1, first bit on the bus is bit 7) followed by the R/W bit (bit 0, 1 = read). If the address equals any of the four entries in `slave_addrs` (entry k in bits 7k+6..7k), an event is raised with `evt_is_addr`=1, `evt_byte` = the full address word and `evt_rw` = the R/W bit.
- R4: In monitor mode with match-all set, every address raises an event. Otherwise an unmatched address raises no event for the whole transfer.
- R5: With `cfg_mon_en`=0, `cfg_match_all` has no effect: an unmatched address raises no event and is not acknowledged.
- R6: After a matched address, every data byte raises an event with `evt_is_addr`=0, the byte as seen on SDA, and `evt_rw` equal to the address R/W bit. This holds for write and read transfers.
- R7: While `cfg_mon_en`=1, `sda_o` stays 1 at all times.
- R8: With `cfg_mon_en`=0, a matched address is acknowledged: `sda_o` is 0 during the ninth clock, so the master samples ACK low.
- R9: While `cfg_mon_en`=1 and `cfg_scl_en`=0, `scl_o` stays 1 at all times.
- R10: When stretching is allowed (`cfg_mon_en`=0, or `cfg_scl_en`=1), `scl_o` goes to 0 at the first falling SCL while an interrupt is pending. It returns to 1 in the cycle after `irq_clr`.
- R11: `evt_byte`, `evt_is_addr` and `evt_rw` change only in a cycle in which `evt_valid` is 1, and hold the last byte after the transfer ends.
- R12: `irq_pending` becomes 1 in the cycle after `evt_valid`. It returns to 0 in the cycle after `irq_clr` when no new event arrives at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive, 0 pulls low, 1 releases |
| cfg_mon_en | input | 1 | Monitor mode enable |
| cfg_scl_en | input | 1 | Clock-line control allowed in monitor mode |
| cfg_match_all | input | 1 | Accept any address in monitor mode |
| slave_addrs | input | NUM_ADDR*7 | Address table, entry k in bits 7k+6..7k |
| irq_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| irq_pending | output | 1 | Interrupt pending |
| evt_valid | output | 1 | One-cycle pulse when a byte is reported |
| evt_is_addr | output | 1 | Reported byte is an address word |
| evt_rw | output | 1 | R/W bit of the current transfer |
| evt_byte | output | 8 | Holding register with the last reported byte |

## Verification
The bench drives directed transfers: a write to a table address in normal mode, and an unmatched address with match-all set in both modes. It also covers a read transfer in which another bench slave drives the data, and a repeated START from a matched to an unmatched address. Together these separate address matching, match-all gating by mode, direction capture and framing on restart. A held interrupt shows whether the clock is stretched or left free. After the directed cases come random transfers with random addresses, directions, lengths, payloads and modes. For each one, a bench function predicts whether an event stream is due, and the bench checks the stream byte by byte together with the ACK level the master sees.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } frame_state_t;

    typedef struct packed {
        logic              valid;
        logic              is_addr;
        logic              rw;
        logic [BYTE_W-1:0] byte_val;
    } byte_evt_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] stage;
    logic [W-1:0]             prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '1;
            prev  <= '1;
        end else begin
            stage[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
            prev <= stage[STAGES-1];
        end
    end

    assign lvl  = stage[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/i2c_mon_match.sv
module i2c_mon_match #(
    parameter int NUM_ADDR = 4,
    parameter int AW       = 7
) (
    input  logic [NUM_ADDR*AW-1:0] addr_list,
    input  logic [AW-1:0]          rx_addr,
    input  logic                   accept_any,
    output logic                   hit
);
    logic [NUM_ADDR-1:0] hits;

    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
        assign hits[g] = (addr_list[g*AW +: AW] == rx_addr);
    end

    assign hit = accept_any | (|hits);
endmodule

// File: rtl/i2c_mon_frame.sv
module i2c_mon_frame
    import i2c_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_lvl,
    input  logic      sda_lvl,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      sda_rise,
    input  logic      sda_fall,
    input  logic      addr_hit,
    output logic [ADDR_W-1:0] cand_addr,
    output byte_evt_t evt,
    output logic      ack_drive
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    frame_state_t      state, state_n;
    logic [CNT_W-1:0]  bit_cnt, bit_cnt_n;
    logic [BYTE_W-1:0] shreg, shreg_n;
    logic              rw_q, rw_n;
    logic              ack_ph, ack_ph_n;
    byte_evt_t         evt_q, evt_n;
    logic              start_det, stop_det;
    logic [BYTE_W-1:0] byte_next;
    logic              last_bit;

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign byte_next = {shreg[BYTE_W-2:0], sda_lvl};
    assign cand_addr = shreg[ADDR_W-1:0];
    assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        state_n         = state;
        bit_cnt_n       = bit_cnt;
        shreg_n         = shreg;
        rw_n            = rw_q;
        ack_ph_n        = ack_ph;
        evt_n           = evt_q;
        evt_n.valid     = 1'b0;
        if (start_det) begin
            state_n   = ST_ADDR;
            bit_cnt_n = '0;
            ack_ph_n  = 1'b0;
        end else if (stop_det) begin
            state_n   = ST_IDLE;
            bit_cnt_n = '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: begin
                end
                ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        shreg_n   = byte_next;
                        bit_cnt_n = bit_cnt + 1'b1;
                        if (last_bit) begin
                            bit_cnt_n = '0;
                            ack_ph_n  = 1'b0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    state_n = ST_ADDR_ACK;
                                    rw_n    = sda_lvl;
                                    evt_n   = '{valid: 1'b1, is_addr: 1'b1,
                                                rw: sda_lvl, byte_val: byte_next};
                                end else begin
                                    state_n = ST_SKIP;
                                end
                            end else begin
                                state_n = ST_DATA_ACK;
                                evt_n   = '{valid: 1'b1, is_addr: 1'b0,
                                            rw: rw_q, byte_val: byte_next};
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph_n = 1'b1;
                        end else begin
                            ack_ph_n = 1'b0;
                            state_n  = ST_DATA;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            ack_ph  <= 1'b0;
            evt_q   <= '0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_cnt_n;
            shreg   <= shreg_n;
            rw_q    <= rw_n;
            ack_ph  <= ack_ph_n;
            evt_q   <= evt_n;
        end
    end

    always_comb begin
        evt = evt_q;
        unique case (state)
            ST_ADDR_ACK: ack_drive = ack_ph;
            ST_DATA_ACK: ack_drive = ack_ph & ~rw_q;
            default:     ack_drive = 1'b0;
        endcase
    end

    // R2: a STOP without a START in the same cycle leaves the frame idle
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));
    // R2: a START always opens an address word
    p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));
    // R4: an unmatched transfer reports nothing
    p_skip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> !evt_q.valid);
    // R11: the holding register changes only with a reported byte
    p_buf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(evt_q.byte_val) |-> evt_q.valid);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_mon_pkg::*;
#(
    parameter int NUM_ADDR    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       scl_o,
    output logic                       sda_o,
    input  logic                       cfg_mon_en,
    input  logic                       cfg_scl_en,
    input  logic                       cfg_match_all,
    input  logic [NUM_ADDR*ADDR_W-1:0] slave_addrs,
    input  logic                       irq_clr,
    output logic                       irq_pending,
    output logic                       evt_valid,
    output logic                       evt_is_addr,
    output logic                       evt_rw,
    output logic [BYTE_W-1:0]          evt_byte
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LINES-1:0]  lvl, rise, fall;
    logic [ADDR_W-1:0] cand_addr;
    logic              addr_hit;
    logic              accept_any;
    logic              stretch_ok;
    logic              ack_drive;
    logic              hold_q;
    logic              irq_q;
    byte_evt_t         evt;

    i2c_mon_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign accept_any = cfg_mon_en & cfg_match_all;
    assign stretch_ok = cfg_mon_en ? cfg_scl_en : 1'b1;

    i2c_mon_match #(.NUM_ADDR(NUM_ADDR), .AW(ADDR_W)) u_match (
        .addr_list (slave_addrs),
        .rx_addr   (cand_addr),
        .accept_any(accept_any),
        .hit       (addr_hit)
    );

    i2c_mon_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl[L_SCL]),
        .sda_lvl  (lvl[L_SDA]),
        .scl_rise (rise[L_SCL]),
        .scl_fall (fall[L_SCL]),
        .sda_rise (rise[L_SDA]),
        .sda_fall (fall[L_SDA]),
        .addr_hit (addr_hit),
        .cand_addr(cand_addr),
        .evt      (evt),
        .ack_drive(ack_drive)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (evt.valid) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (!stretch_ok || (irq_clr && !evt.valid)) begin
            hold_q <= 1'b0;
        end else if (irq_q && fall[L_SCL]) begin
            hold_q <= 1'b1;
        end
    end

    always_comb begin
        scl_o       = ~hold_q;
        sda_o       = ~(ack_drive & ~cfg_mon_en);
        irq_pending = irq_q;
        evt_valid   = evt.valid;
        evt_is_addr = evt.is_addr;
        evt_rw      = evt.rw;
        evt_byte    = evt.byte_val;
    end

    // R7: monitor mode never pulls data low
    p_sda_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mon_en |-> sda_o);
    // R9: monitor mode without clock control leaves SCL alone
    p_scl_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mon_en && !cfg_scl_en) |-> scl_o);
    // R10: a clear strobe releases the clock on the next cycle
    p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !evt_valid) |=> scl_o);
    // R12: a reported byte leaves the interrupt pending
    p_irq_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> irq_pending);
    // R12: a clear without a new byte drops the flag
    p_irq_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !evt_valid) |=> !irq_pending);
endmodule

// File: tb/i2c_bus_monitor_test.sv
module i2c_bus_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 8;
    localparam int NADDR      = 4;
    localparam int WDOG       = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, s_sda = 1'b1;
    logic cfg_mon_en = 1'b0, cfg_scl_en = 1'b0, cfg_match_all = 1'b0;
    logic irq_clr = 1'b0;
    logic [NADDR*7-1:0] slave_addrs = {7'h5A, 7'h3C, 7'h21, 7'h50};
    logic scl_o, sda_o, irq_pending, evt_valid, evt_is_addr, evt_rw;
    logic [7:0] evt_byte;
    logic scl_line, sda_line;

    int checks = 0, errors = 0;
    int ev_cnt = 0, sda_drv = 0, scl_drv = 0, buf_glitch = 0;
    logic [7:0] ev_b [64];
    logic       ev_a [64];
    logic       ev_r [64];
    logic [7:0] tx_data [8];
    logic       auto_clr = 1'b1;
    logic [7:0] prev_byte = '0;
    logic       done = 1'b0;

    assign scl_line = m_scl & scl_o;
    assign sda_line = m_sda & s_sda & sda_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_monitor #(.NUM_ADDR(NADDR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_o(scl_o), .sda_o(sda_o), .cfg_mon_en(cfg_mon_en),
        .cfg_scl_en(cfg_scl_en), .cfg_match_all(cfg_match_all),
        .slave_addrs(slave_addrs), .irq_clr(irq_clr),
        .irq_pending(irq_pending), .evt_valid(evt_valid),
        .evt_is_addr(evt_is_addr), .evt_rw(evt_rw), .evt_byte(evt_byte)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (evt_valid && ev_cnt < 64) begin
                ev_b[ev_cnt] = evt_byte;
                ev_a[ev_cnt] = evt_is_addr;
                ev_r[ev_cnt] = evt_rw;
                ev_cnt = ev_cnt + 1;
            end
            if (!evt_valid && evt_byte != prev_byte) buf_glitch = buf_glitch + 1;
            prev_byte = evt_byte;
            if (!sda_o) sda_drv = sda_drv + 1;
            if (!scl_o) scl_drv = scl_drv + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_hit(input logic [6:0] a, input logic mon, input logic mall);
        if (mon && mall) return 1'b1;
        for (int k = 0; k < NADDR; k++) begin
            if (slave_addrs[k*7 +: 7] == a) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic half();
        repeat (HB) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        while (scl_line == 1'b0) @(negedge clk);
        half();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half(); scl_up();
        m_sda = 1'b0; half();
        m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half(); scl_up();
        m_sda = 1'b1; half();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; half(); scl_up(); m_scl = 1'b0; half();
        end
        m_sda = 1'b1; half(); scl_up();
        ack = sda_line;
        m_scl = 1'b0; half();
    endtask

    task automatic get_byte(input logic [7:0] b, input logic last);
        for (int i = 7; i >= 0; i--) begin
            s_sda = b[i]; half(); scl_up(); m_scl = 1'b0; half();
        end
        s_sda = 1'b1;
        m_sda = last; half(); scl_up(); m_scl = 1'b0; half();
        m_sda = 1'b1;
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input int n, output logic ack);
        logic dummy;
        bus_start();
        put_byte({a, rw}, ack);
        for (int i = 0; i < n; i++) begin
            if (rw) get_byte(tx_data[i], (i == n - 1));
            else    put_byte(tx_data[i], dummy);
        end
        bus_stop();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_events(input string req, input logic [6:0] a, input logic rw,
                                input int n, input logic hit);
        check({req, " event count"}, ev_cnt, hit ? n + 1 : 0);
        if (hit && ev_cnt == n + 1) begin
            check({req, " addr word"}, ev_b[0], {a, rw});
            check({req, " addr flag"}, ev_a[0], 1);
            for (int i = 1; i <= n; i++) begin
                check({req, " data byte"}, ev_b[i], tx_data[i-1]);
                if (ev_a[i] != 1'b0 || ev_r[i] != rw) check({req, " data flags"}, {ev_a[i], ev_r[i]}, {1'b0, rw});
            end
        end
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin : auto_clear
        forever begin
            @(negedge clk);
            if (auto_clr && irq_pending) begin
                repeat (20) @(negedge clk);
                if (auto_clr) clear_irq();
            end
        end
    end

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        int   seed_init;
        seed_init = $urandom(32'h5EED_0C1A);
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 irq", irq_pending, 0);
        check("R1 evt", evt_valid, 0);
        check("R1 scl_o", scl_o, 1);
        check("R1 sda_o", sda_o, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 R6 R8: normal-mode write to a table address
        tx_data[0] = 8'hA5; tx_data[1] = 8'h3C;
        ev_cnt = 0;
        xfer(7'h21, 1'b0, 2, ack);
        check("R8 ack", ack, 0);
        check_events("R3 R6 write", 7'h21, 1'b0, 2, 1'b1);
        check("R11 held byte", evt_byte, 8'h3C);

        // R5: match-all ignored outside monitor mode
        cfg_match_all = 1'b1; ev_cnt = 0;
        xfer(7'h11, 1'b0, 1, ack);
        check("R5 events", ev_cnt, 0);
        check("R5 no ack", ack, 1);

        // R4 R7: monitor mode match-all, no SDA drive
        cfg_mon_en = 1'b1; cfg_scl_en = 1'b1; ev_cnt = 0; sda_drv = 0;
        tx_data[0] = 8'h01;
        xfer(7'h11, 1'b0, 1, ack);
        check_events("R4 match-all", 7'h11, 1'b0, 1, 1'b1);
        check("R7 sda quiet", sda_drv, 0);

        // R4: monitor without match-all, unmatched
        cfg_match_all = 1'b0; ev_cnt = 0;
        xfer(7'h12, 1'b0, 1, ack);
        check("R4 unmatched", ev_cnt, 0);

        // R6 R7: monitored read, data from another slave
        ev_cnt = 0; sda_drv = 0;
        tx_data[0] = 8'hC3; tx_data[1] = 8'h7E; tx_data[2] = 8'h00;
        xfer(7'h5A, 1'b1, 3, ack);
        check_events("R6 read", 7'h5A, 1'b1, 3, 1'b1);
        check("R7 sda quiet read", sda_drv, 0);
        check("R6 rw flag", evt_rw, 1);

        // R2: repeated START to an unmatched address stops reporting
        ev_cnt = 0;
        bus_start(); put_byte({7'h50, 1'b0}, ack);
        put_byte(8'h99, ack);
        bus_start(); put_byte({7'h33, 1'b0}, ack);
        put_byte(8'h44, ack);
        bus_stop(); repeat (6) @(negedge clk);
        check("R2 restart count", ev_cnt, 2);
        check("R2 last byte", evt_byte, 8'h99);

        // R9 R12: monitor without clock control, irq left pending
        cfg_scl_en = 1'b0; auto_clr = 1'b0; scl_drv = 0; ev_cnt = 0;
        tx_data[0] = 8'h66;
        xfer(7'h3C, 1'b0, 1, ack);
        check_events("R9 free clock", 7'h3C, 1'b0, 1, 1'b1);
        check("R9 scl never held", scl_drv, 0);
        check("R12 pending", irq_pending, 1);
        clear_irq();
        check("R12 cleared", irq_pending, 0);

        // R10: clock stretch until clear
        cfg_scl_en = 1'b1;
        fork
            begin xfer(7'h50, 1'b1, 0, ack); end
            begin
                wait (irq_pending);
                repeat (100) @(negedge clk);
                check("R10 held", scl_o, 0);
                check("R10 line low", scl_line, 0);
                clear_irq();
                check("R10 released", scl_o, 1);
            end
        join
        auto_clr = 1'b1;

        // random transfers
        for (int t = 0; t < 24; t++) begin
            logic [6:0] a;
            logic rw, mon, mall, hit;
            int n;
            mon  = $urandom_range(0, 1);
            mall = $urandom_range(0, 1);
            if ($urandom_range(0, 1)) a = slave_addrs[$urandom_range(0, NADDR-1)*7 +: 7];
            else a = 7'($urandom_range(0, 127));
            rw = $urandom_range(0, 1);
            n  = $urandom_range(1, 3);
            for (int i = 0; i < n; i++) tx_data[i] = 8'($urandom_range(0, 255));
            cfg_mon_en = mon; cfg_match_all = mall; cfg_scl_en = 1'b1;
            hit = exp_hit(a, mon, mall);
            ev_cnt = 0; sda_drv = 0;
            xfer(a, rw, n, ack);
            check_events("R3 R4 R6 random", a, rw, n, hit);
            if (mon) check("R7 random sda", sda_drv, 0);
            else     check("R8 R5 random ack", ack, hit ? 0 : 1);
        end

        check("R11 buffer glitches", buf_glitch, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule